// File: doc/BRIEF.md
# Two-Round SHA-256 Compression Engine

This block computes the SHA-256 compression function over a stream of already padded 512-bit blocks. It does two of the 64 rounds in every clock cycle. The caller streams sixteen 32-bit words per block and marks the final block of a message. The block collects a whole block in a read-ahead buffer before compression starts. While one block is being compressed, the buffer accepts the next block, so a message of several blocks runs without a gap between blocks.

The message schedule runs as a sliding window of sixteen words. The sums of schedule word and round constant are formed one cycle before the rounds use them, so the addition of the constant stays off the round path. After the last round pair, the working variables are added into the chaining state. That state is the digest output. Once the final block has been accumulated, the done output rises and the digest stays held until the next init pulse starts a new message.

Top module: `sha2x_core`

## Requirements
- R1: After reset, done is low, word_ready is high and digest equals the SHA-256 initial value 6A09E667 BB67AE85 3C6EF372 A54FF53A 510E527F 9B05688C 1F83D9AB 5BE0CD19, with the first of these in bits 255:224.
- R2: One cycle after init is sampled high, done is low, word_ready is high and digest equals the initial value. Any words already buffered are discarded and any compression in progress is abandoned.
- R3: The first word accepted for a block is schedule word 0. Each word carries four message bytes with the earliest byte in bits 31:24. The digest carries chaining word 0 in bits 255:224 down to word 7 in bits 31:0.
- R4: A word is taken at a rising edge where word_valid and word_ready are both high. word_ready goes low in the cycle after the sixteenth word of a block is taken and stays low until that block moves into compression. Words offered while word_ready is low are not taken.
- R5: last_in is sampled only together with the sixteenth word of a block. Its value on the other fifteen words has no effect, and a block whose sixteenth word arrives with last_in low never raises done.
- R6: A block that completes its buffer while the engine is idle raises done 35 cycles after the edge that takes its sixteenth word: one transfer cycle, one prepare cycle, 32 two-round steps and one accumulate cycle.
- R7: The next block is accepted during compression. If it is complete when the current block accumulates, it enters compression on the next cycle. For a two-block message streamed without gaps, done rises 69 cycles after the edge that takes the first block's sixteenth word.
- R8: After each block, every chaining word is increased modulo 2^32 by the matching working variable, so the final digest is the standard SHA-256 value of the message. The digest changes only on accumulate cycles.
- R9: Once high, done stays high and digest stays unchanged until init.
- R10: Each message that follows an init starts from the initial value and does not depend on any earlier message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Start a new message: clear buffer, state and done |
| word_valid | input | 1 | word_in holds a message word |
| word_in | input | 32 | Message word, earliest byte in bits 31:24 |
| last_in | input | 1 | Marks the block as the last of the message (sampled with the sixteenth word) |
| word_ready | output | 1 | The read-ahead buffer can take a word |
| done | output | 1 | The final block has been accumulated; digest is valid |
| digest | output | 256 | Chaining state, word 0 in the top bits |

## Verification
The hardest situation to reach is a full next block sitting in the read-ahead buffer at the very cycle the current block accumulates, while the caller keeps offering words that must be refused. The stimulus gets there by streaming a two-block message with no idle cycles, so the second block is complete long before the first finishes. It then holds word_valid high with junk data while word_ready is low. The digest must still match the known two-block result, and the cycle count must show no gap between the blocks. A separate sequence pulses init while a block is being compressed, and another while a partial block is buffered, to show that both are abandoned.

// File: rtl/sha2x_pkg.sv
`timescale 1ns/1ps
package sha2x_pkg;

   localparam int unsigned WORD_W     = 32;
   localparam int unsigned BLK_WORDS  = 16;
   localparam int unsigned NUM_ROUNDS = 64;
   localparam int unsigned KIDX_W     = $clog2(NUM_ROUNDS);

   typedef logic [WORD_W-1:0] word_t;

   // Working variables / chaining state, a in the most significant word
   typedef struct packed {
      word_t a; word_t b; word_t c; word_t d;
      word_t e; word_t f; word_t g; word_t h;
   } vars_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PREP = 3'd1,
      ST_COMP = 3'd2,
      ST_ACC  = 3'd3,
      ST_DONE = 3'd4
   } phase_e;

   localparam vars_t IV_VARS = '{
      a: 32'h6a09e667, b: 32'hbb67ae85, c: 32'h3c6ef372, d: 32'ha54ff53a,
      e: 32'h510e527f, f: 32'h9b05688c, g: 32'h1f83d9ab, h: 32'h5be0cd19
   };

   localparam word_t KTAB [NUM_ROUNDS] = '{
      32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
      32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
      32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
      32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
      32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
      32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
      32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
      32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
      32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
      32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
      32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
      32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
      32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
      32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
      32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
      32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
   };

   function automatic word_t rotr(word_t x, int unsigned n);
      return (x >> n) | (x << (WORD_W - n));
   endfunction

   function automatic word_t big_sig0(word_t x);
      return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
   endfunction

   function automatic word_t big_sig1(word_t x);
      return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
   endfunction

   function automatic word_t sml_sig0(word_t x);
      return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
   endfunction

   function automatic word_t sml_sig1(word_t x);
      return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
   endfunction

   // One compression round; wk is the pre-added schedule word plus constant
   function automatic vars_t round_step(vars_t v, word_t wk);
      vars_t r;
      word_t t1;
      word_t t2;
      t1 = v.h + big_sig1(v.e) + ((v.e & v.f) ^ (~v.e & v.g)) + wk;
      t2 = big_sig0(v.a) + ((v.a & v.b) ^ (v.a & v.c) ^ (v.b & v.c));
      r.a = t1 + t2;
      r.b = v.a;
      r.c = v.b;
      r.d = v.c;
      r.e = v.d + t1;
      r.f = v.e;
      r.g = v.f;
      r.h = v.g;
      return r;
   endfunction

   function automatic vars_t add_vars(vars_t x, vars_t y);
      vars_t r;
      r.a = x.a + y.a; r.b = x.b + y.b; r.c = x.c + y.c; r.d = x.d + y.d;
      r.e = x.e + y.e; r.f = x.f + y.f; r.g = x.g + y.g; r.h = x.h + y.h;
      return r;
   endfunction

endpackage

// File: rtl/sha2x_msgbuf.sv
`timescale 1ns/1ps
// Read-ahead block buffer: collects one full block of words while the
// datapath may still be busy with the previous one.
module sha2x_msgbuf
   import sha2x_pkg::*;
#(
   parameter int unsigned NWORDS = BLK_WORDS
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr,
   input  logic        word_valid,
   input  word_t       word_in,
   input  logic        last_in,
   input  logic        take,
   output logic        ready,
   output logic        full,
   output logic        blk_last,
   output logic [$clog2(NWORDS+1)-1:0] fill_cnt,
   output word_t       blk [NWORDS]
);

   localparam int unsigned CNT_W = $clog2(NWORDS + 1);
   localparam int unsigned IDX_W = $clog2(NWORDS);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NWORDS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NWORDS - 1);

   if (NWORDS < 2) begin : g_chk_words
      $error("sha2x_msgbuf: NWORDS must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic             last_q;
   logic             accept;

   assign full     = (cnt == CNT_FULL);
   assign ready    = !full;
   assign accept   = word_valid && !full;
   assign blk_last = last_q;
   assign fill_cnt = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         last_q <= 1'b0;
      end else if (clr || take) begin
         cnt    <= '0;
      end else if (accept) begin
         cnt <= cnt + 1'b1;
         if (cnt == CNT_LAST) begin
            last_q <= last_in;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         blk[cnt[IDX_W-1:0]] <= word_in;
      end
   end

endmodule

// File: rtl/sha2x_sched.sv
`timescale 1ns/1ps
// Message schedule window; produces UNROLL pre-added W+K terms per step,
// registered one cycle ahead of the rounds that consume them.
module sha2x_sched
   import sha2x_pkg::*;
#(
   parameter int unsigned UNROLL = 2
)(
   input  logic              clk,
   input  logic              load,
   input  word_t             blk [BLK_WORDS],
   input  logic              step,
   input  logic [KIDX_W-1:0] kbase,
   output word_t             wk [UNROLL]
);

   if (UNROLL < 1 || UNROLL > 2) begin : g_chk_unroll
      $error("sha2x_sched: UNROLL must be 1 or 2");
   end

   word_t win     [BLK_WORDS];
   word_t nw      [UNROLL];
   word_t wk_nxt  [UNROLL];

   // New words depend only on the current window for UNROLL <= 2
   for (genvar j = 0; j < UNROLL; j++) begin : g_lane
      assign nw[j] = sml_sig1(win[14+j]) + win[9+j] + sml_sig0(win[1+j]) + win[j];
      assign wk_nxt[j] = win[j] + KTAB[kbase + KIDX_W'(j)];
   end

   always_ff @(posedge clk) begin
      if (load) begin
         win <= blk;
      end else if (step) begin
         for (int k = 0; k < int'(BLK_WORDS - UNROLL); k++) begin
            win[k] <= win[k + UNROLL];
         end
         for (int j = 0; j < int'(UNROLL); j++) begin
            win[BLK_WORDS - UNROLL + j] <= nw[j];
            wk[j] <= wk_nxt[j];
         end
      end
   end

endmodule

// File: rtl/sha2x_rounds.sv
`timescale 1ns/1ps
// Unfolded round datapath: UNROLL rounds chained combinationally.
module sha2x_rounds
   import sha2x_pkg::*;
#(
   parameter int unsigned UNROLL = 2
)(
   input  vars_t v_in,
   input  word_t wk [UNROLL],
   output vars_t v_out
);

   always_comb begin
      v_out = v_in;
      for (int j = 0; j < int'(UNROLL); j++) begin
         v_out = round_step(v_out, wk[j]);
      end
   end

endmodule

// File: rtl/sha2x_core.sv
`timescale 1ns/1ps
module sha2x_core
   import sha2x_pkg::*;
#(
   parameter int unsigned UNROLL = 2
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init,
   input  logic         word_valid,
   input  logic [31:0]  word_in,
   input  logic         last_in,
   output logic         word_ready,
   output logic         done,
   output logic [255:0] digest
);

   localparam int unsigned STEPS = NUM_ROUNDS / UNROLL;
   localparam int unsigned RC_W  = $clog2(STEPS);
   localparam logic [RC_W-1:0] RC_LAST = RC_W'(STEPS - 1);
   localparam int unsigned CNT_W = $clog2(BLK_WORDS + 1);

   if (UNROLL != 1 && UNROLL != 2) begin : g_chk_unroll
      $error("sha2x_core: UNROLL must be 1 or 2");
   end
   if (NUM_ROUNDS % UNROLL != 0) begin : g_chk_div
      $error("sha2x_core: UNROLL must divide the round count");
   end

   phase_e            st;
   vars_t             hs;
   vars_t             wv;
   vars_t             wv_nxt;
   logic              cur_last;
   logic [RC_W-1:0]   rc;
   logic [KIDX_W-1:0] kbase;
   logic              take;
   logic              buf_full;
   logic              buf_last;
   logic [CNT_W-1:0]  fill_cnt;
   word_t             blk [BLK_WORDS];
   word_t             wk  [UNROLL];

   assign take = buf_full && !init &&
                 ((st == ST_IDLE) || ((st == ST_ACC) && !cur_last));

   // Constant index of the pair needed by the next step
   always_comb begin
      if (st == ST_COMP) begin
         kbase = KIDX_W'((KIDX_W'(rc) + KIDX_W'(1)) * KIDX_W'(UNROLL));
      end else begin
         kbase = '0;
      end
   end

   sha2x_msgbuf #(.NWORDS(BLK_WORDS)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (init),
      .word_valid (word_valid),
      .word_in    (word_in),
      .last_in    (last_in),
      .take       (take),
      .ready      (word_ready),
      .full       (buf_full),
      .blk_last   (buf_last),
      .fill_cnt   (fill_cnt),
      .blk        (blk)
   );

   sha2x_sched #(.UNROLL(UNROLL)) u_sched (
      .clk   (clk),
      .load  (take),
      .blk   (blk),
      .step  ((st == ST_PREP) || (st == ST_COMP)),
      .kbase (kbase),
      .wk    (wk)
   );

   sha2x_rounds #(.UNROLL(UNROLL)) u_rounds (
      .v_in  (wv),
      .wk    (wk),
      .v_out (wv_nxt)
   );

   // Sequencer and chaining state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         rc       <= '0;
         cur_last <= 1'b0;
         hs       <= IV_VARS;
      end else if (init) begin
         st       <= ST_IDLE;
         rc       <= '0;
         cur_last <= 1'b0;
         hs       <= IV_VARS;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (take) begin
                  st       <= ST_PREP;
                  cur_last <= buf_last;
               end
            end
            ST_PREP: begin
               st <= ST_COMP;
               rc <= '0;
            end
            ST_COMP: begin
               if (rc == RC_LAST) begin
                  st <= ST_ACC;
               end else begin
                  rc <= rc + 1'b1;
               end
            end
            ST_ACC: begin
               hs <= add_vars(hs, wv);
               if (cur_last) begin
                  st <= ST_DONE;
               end else if (take) begin
                  st       <= ST_PREP;
                  cur_last <= buf_last;
               end else begin
                  st <= ST_IDLE;
               end
            end
            ST_DONE: st <= ST_DONE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // Working variables: seeded from the chaining state, then unfolded rounds
   always_ff @(posedge clk) begin
      if (st == ST_PREP) begin
         wv <= hs;
      end else if (st == ST_COMP) begin
         wv <= wv_nxt;
      end
   end

   assign done   = (st == ST_DONE);
   assign digest = hs;

endmodule

// File: rtl/sha2x_core_chk.sv
`timescale 1ns/1ps
module sha2x_core_chk
   import sha2x_pkg::*;
#(
   parameter int unsigned UNROLL = 2
)(
   input logic         clk,
   input logic         rst_n,
   input logic         init,
   input logic         word_valid,
   input logic         word_ready,
   input logic         done,
   input logic [255:0] digest,
   input phase_e       phase,
   input logic [$clog2(NUM_ROUNDS/UNROLL)-1:0] rc,
   input logic         buf_full,
   input logic         cur_last,
   input logic [$clog2(BLK_WORDS+1)-1:0] fill
);

   localparam int unsigned RC_W  = $clog2(NUM_ROUNDS / UNROLL);
   localparam int unsigned CNT_W = $clog2(BLK_WORDS + 1);
   localparam logic [RC_W-1:0]  RC_END   = RC_W'(NUM_ROUNDS / UNROLL - 1);
   localparam logic [CNT_W-1:0] FILL_END = CNT_W'(BLK_WORDS - 1);

   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) init |=> (!done && word_ready && digest == IV_VARS)); // R2
   AST_FILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (word_valid && word_ready && fill == FILL_END && !init) |=> !word_ready); // R4
   AST_ROUND_STEP:  assert property (@(posedge clk) disable iff (!rst_n) (phase == ST_COMP && rc != RC_END && !init) |=> (phase == ST_COMP && rc == RC_W'($past(rc) + 1'b1))); // R6
   AST_NO_GAP:      assert property (@(posedge clk) disable iff (!rst_n) (phase == ST_ACC && buf_full && !cur_last && !init) |=> phase == ST_PREP); // R7
   AST_DIGEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (phase != ST_ACC && !init) |=> $stable(digest)); // R8
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (done && !init) |=> (done && $stable(digest))); // R9

endmodule

bind sha2x_core sha2x_core_chk #(.UNROLL(UNROLL)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .init       (init),
   .word_valid (word_valid),
   .word_ready (word_ready),
   .done       (done),
   .digest     (digest),
   .phase      (st),
   .rc         (rc),
   .buf_full   (buf_full),
   .cur_last   (cur_last),
   .fill       (fill_cnt)
);

// File: tb/sha2x_core_bench.sv
`timescale 1ns/1ps
module sha2x_core_bench;

   localparam logic [255:0] IV = 256'h6a09e667bb67ae853c6ef372a54ff53a510e527f9b05688c1f83d9ab5be0cd19;
   localparam int NVEC = 3;
   localparam int NBLK [NVEC] = '{1, 1, 2};
   localparam logic [255:0] EXP [NVEC] = '{
      256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855,
      256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad,
      256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1
   };
   // Expected done latency from the edge taking the first block's 16th word
   localparam int LAT [NVEC] = '{35, 35, 69};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         init = 1'b0;
   logic         word_valid = 1'b0;
   logic [31:0]  word_in = '0;
   logic         last_in = 1'b0;
   logic         word_ready;
   logic         done;
   logic [255:0] digest;

   int ntests = 0;
   int nfail  = 0;
   int cyc    = 0;
   int acc_cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sha2x_core u_sha2x_core (
      .clk(clk), .rst_n(rst_n), .init(init), .word_valid(word_valid),
      .word_in(word_in), .last_in(last_in), .word_ready(word_ready),
      .done(done), .digest(digest)
   );

   // Padded message words (R3 byte order: earliest byte in bits 31:24)
   function automatic logic [31:0] msg_word(int v, int k);
      case (v)
         0: return (k == 0) ? 32'h80000000 : 32'h0;
         1: return (k == 0) ? 32'h61626380 : (k == 15) ? 32'h00000018 : 32'h0;
         default: begin
            if (k < 14) return {8'(8'h61 + k), 8'(8'h62 + k), 8'(8'h63 + k), 8'(8'h64 + k)};
            if (k == 14) return 32'h80000000;
            if (k == 31) return 32'h000001c0;
            return 32'h0;
         end
      endcase
   endfunction

   task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
      ntests++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_init();
      @(negedge clk); init = 1'b1;
      @(negedge clk); init = 1'b0;
   endtask

   // Called at a negedge; returns at the negedge after the accepting edge
   task automatic put_word(input logic [31:0] w, input logic l);
      word_valid = 1'b1; word_in = w; last_in = l;
      while (!word_ready) @(negedge clk);
      @(negedge clk);
      acc_cyc = cyc;
      word_valid = 1'b0; last_in = 1'b0;
   endtask

   task automatic wait_done(output int when);
      when = -1;
      for (int i = 0; i < 400; i++) begin
         if (done) begin when = cyc; break; end
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      nfail++; ntests++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

   initial begin
      int t16;
      int td;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 done", {255'b0, done}, 256'd0);
      chk("R1 ready", {255'b0, word_ready}, 256'd1);
      chk("R1 digest", digest, IV);

      // Vector table walk: R3/R8/R10 digests, R6/R7 latency, R5 stray last flags
      for (int v = 0; v < NVEC; v++) begin
         do_init();
         t16 = 0;
         for (int k = 0; k < 16 * NBLK[v]; k++) begin
            put_word(msg_word(v, k), (k / 16 == NBLK[v] - 1) || (k % 16 != 15));
            if (k == 15) t16 = acc_cyc;
         end
         wait_done(td);
         chk($sformatf("R8 R10 R3 R5 digest vec%0d", v), digest, EXP[v]);
         chk($sformatf("R6 R7 latency vec%0d", v), 256'(td - t16), 256'(LAT[v]));
      end

      // R9: done and digest held
      repeat (20) @(negedge clk);
      chk("R9 done held", {255'b0, done}, 256'd1);
      chk("R9 digest held", digest, EXP[2]);

      // R2: init after done
      do_init();
      chk("R2 done cleared", {255'b0, done}, 256'd0);
      chk("R2 digest reset", digest, IV);
      chk("R2 ready", {255'b0, word_ready}, 256'd1);

      // R4: second block buffered, junk offered while ready is low
      for (int k = 0; k < 32; k++) put_word(msg_word(2, k), k == 31);
      chk("R4 ready low when next block held", {255'b0, word_ready}, 256'd0);
      word_valid = 1'b1;
      for (int i = 0; i < 10; i++) begin
         word_in = 32'hdead0000 + 32'(i); last_in = 1'b1;
         @(negedge clk);
         if (word_ready) break;
      end
      word_valid = 1'b0; last_in = 1'b0;
      wait_done(td);
      chk("R4 junk ignored digest", digest, EXP[2]);

      // R5: 16th word with last low never raises done
      do_init();
      for (int k = 0; k < 16; k++) put_word(msg_word(1, k), k != 15);
      repeat (60) @(negedge clk);
      chk("R5 no done without last", {255'b0, done}, 256'd0);

      // R2: abort mid-compression and discard a partial block
      do_init();
      for (int k = 0; k < 16; k++) put_word(msg_word(1, k), 1'b1);
      repeat (10) @(negedge clk);
      do_init();
      chk("R2 abort digest", digest, IV);
      chk("R2 abort done", {255'b0, done}, 256'd0);
      for (int k = 0; k < 5; k++) put_word(32'hbad0bad0, 1'b1);
      do_init();
      for (int k = 0; k < 16; k++) put_word(msg_word(1, k), 1'b1);
      wait_done(td);
      chk("R2 R10 digest after abort", digest, EXP[1]);

      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

endmodule